// File: doc/BRIEF.md
# Dual-Clock FIFO with Half-Full Flag

This block is a first-in first-out buffer between a write clock domain and a read clock domain. The two clocks may be unrelated or may be the same net. Words are stored on the write clock while the write enable is low and the buffer is not full. On the read clock a registered output is loaded with the oldest unread word, but only when the read enable is low and the buffer is not empty. Data never appears at the output on its own. Each word, including the first word written into an empty buffer, must be requested.

Three active-low flags report state. The empty flag is kept in the read domain and the full flag in the write domain. The half-full flag is set by the write side and cleared by the read side. Pointers cross between the domains in Gray code through two-flop synchronizers. The output enable does not tri-state a net inside the block. It controls a separate drive-enable output that goes to the pad driver, which releases the bus when that enable is low.

A single active-low reset clears both domains. Each domain applies the reset on its own clock edge and releases it two edges after the input goes high. A reset is required before the first write.

Top module: `dcfifo_hf`

## Requirements
- R1: While reset is active, and after it is released with no further activity, `full_n`=1, `empty_n`=0, `half_n`=1 and the output register `q`=0. Write and read enables applied during reset store nothing and read nothing.
- R2: On a write-clock edge with `wen_n`=0 and `full_n`=1, `din` is stored. Words are read out in the order they were written.
- R3: With no reads pending, `full_n` goes low on the write edge that stores word DEPTH. Writes while `full_n`=0 are dropped and leave the stored contents unchanged.
- R4: On a read-clock edge with `ren_n`=0 and `empty_n`=1, `q` loads the oldest unread word. With `ren_n`=1, `q` holds its value.
- R5: A write into an empty buffer does not change `q` until a read requests the word.
- R6: `empty_n` goes low on the read edge that removes the last word. A read while `empty_n`=0 leaves `q` unchanged.
- R7: After a write into an empty buffer, `empty_n` rises within 4 read-clock edges. After a read from a full buffer, `full_n` rises within 4 write-clock edges.
- R8: `half_n` goes low on the write edge that stores word DEPTH/2+1.
- R9: `half_n` returns high on the read edge that leaves DEPTH/2 words stored.
- R10: `q_en`=0 (bus released) while `oe_n`=1. `q_en`=1 while `oe_n`=0, and `q` always carries the output register.
- R11: A reset with words stored discards them. After release, the next word read is the first word written after the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset for both domains |
| wen_n | input | 1 | Active-low write enable |
| din | input | DATA_W | Write data |
| ren_n | input | 1 | Active-low read enable |
| oe_n | input | 1 | Active-low output enable |
| q | output | DATA_W | Output register contents |
| q_en | output | 1 | Drive enable for the output pads |
| empty_n | output | 1 | Low when no unread words remain |
| full_n | output | 1 | Low when DEPTH words are stored |
| half_n | output | 1 | Low when more than DEPTH/2 words are stored |

## Verification
The bench builds the block with DEPTH=16 and DATA_W=16, and ties both clocks to one source. At this depth every fill level from 1 to 16 can be written and then drained in a single run. Each write is checked against the half-full and full flag values computed from the fill count, and each read against the empty and half-full values for the words remaining. The small depth also puts the full boundary, overflow attempts, reads while empty, reset with data stored and a stretch of simultaneous reads and writes within a short run.

// File: rtl/dcfifo_pkg.sv
// Package: Gray-code helpers shared by both clock domains of the FIFO.
// Assumes pointer widths up to 32 bits; callers slice the result.
package dcfifo_pkg;
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction
endpackage

// File: rtl/dcfifo_sync.sv
// Two-flop synchronizer for a bus that changes at most one bit per source
// edge (Gray pointer or toggle bit). Synchronous active-low clear.
module dcfifo_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Capture and re-time the foreign-domain value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dcfifo_wside.sv
// Write-domain control: write pointer, full flag and the half-full set toggle.
// Assumes rgray_s and clr_tog_s are already synchronized to clk.
module dcfifo_wside
    import dcfifo_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wen_n,
    input  logic [PW-1:0] rgray_s,
    input  logic          clr_tog_s,
    output logic [AW-1:0] waddr,
    output logic          wr_en,
    output logic [PW-1:0] wgray,
    output logic          full_n,
    output logic          set_tog
);
    localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);

    logic [PW-1:0] wptr, wptr_nx, rbin, cnt_nx;

    assign wr_en   = rst_n && !wen_n && full_n;
    assign wptr_nx = wptr + PW'(wr_en);
    assign rbin    = PW'(from_gray(32'(rgray_s)));
    assign cnt_nx  = wptr_nx - rbin;
    assign waddr   = wptr[AW-1:0];

    // Advance the pointer, refresh full, raise the half-full event when armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            wgray   <= '0;
            full_n  <= 1'b1;
            set_tog <= 1'b0;
        end else begin
            wptr   <= wptr_nx;
            wgray  <= PW'(to_gray(32'(wptr_nx)));
            full_n <= (cnt_nx != FULL_CNT);
            if (set_tog == clr_tog_s && cnt_nx > HALF_CNT)
                set_tog <= ~set_tog;
        end
    end

    AST_WCOUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (PW'(wptr - rbin) <= FULL_CNT)); // R3
    AST_FULL_FALLS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full_n) |-> $past(wr_en)); // R3
endmodule

// File: rtl/dcfifo_rside.sv
// Read-domain control: read pointer, empty flag, half-full clear toggle and
// the non-fall-through output register. Assumes wgray_s, set_tog_s synchronized.
module dcfifo_rside
    import dcfifo_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_n,
    input  logic [PW-1:0]     wgray_s,
    input  logic              set_tog_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [AW-1:0]     raddr,
    output logic [PW-1:0]     rgray,
    output logic              empty_n,
    output logic              clr_tog,
    output logic [DATA_W-1:0] dout
);
    localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);

    logic [PW-1:0] rptr, rptr_nx, wbin;
    logic          rd_ok;

    assign rd_ok   = rst_n && !ren_n && empty_n;
    assign rptr_nx = rptr + PW'(rd_ok);
    assign wbin    = PW'(from_gray(32'(wgray_s)));
    assign raddr   = rptr[AW-1:0];

    // Advance the pointer, refresh empty, clear the half-full event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr    <= '0;
            rgray   <= '0;
            empty_n <= 1'b0;
            clr_tog <= 1'b0;
        end else begin
            rptr    <= rptr_nx;
            rgray   <= PW'(to_gray(32'(rptr_nx)));
            empty_n <= (wbin != rptr_nx);
            if (set_tog_s != clr_tog && PW'(wbin - rptr_nx) <= HALF_CNT)
                clr_tog <= ~clr_tog;
        end
    end

    // Output register: loads only on a granted read, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     dout <= '0;
        else if (rd_ok) dout <= rd_data;
    end

    AST_Q_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ren_n |=> $stable(dout)); // R4
    AST_EMPTY_FALLS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(empty_n) |-> $past(rd_ok)); // R6
    AST_Q_CLEARED: assert property (@(posedge clk)
        $past(!rst_n) |-> (dout == '0)); // R1
endmodule

// File: rtl/dcfifo_hf.sv
// Top: dual-clock FIFO with active-low empty, full and half-full flags.
// Assumes DEPTH is a power of two >= 4; rst_n is held for several edges of both clocks.
module dcfifo_hf #(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              wen_n,
    input  logic [DATA_W-1:0] din,
    input  logic              ren_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] q,
    output logic              q_en,
    output logic              empty_n,
    output logic              full_n,
    output logic              half_n
);
    logic [1:0]        wrs, rrs;
    logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
    logic              set_tog, clr_tog, set_tog_s, clr_tog_s, wr_en;
    logic [AW-1:0]     waddr, raddr;
    logic [DATA_W-1:0] mem [DEPTH];

    // Per-domain reset: applied on the next edge, released after two edges.
    always_ff @(posedge wclk) wrs <= rst_n ? {wrs[0], 1'b1} : 2'b00;
    always_ff @(posedge rclk) rrs <= rst_n ? {rrs[0], 1'b1} : 2'b00;

    dcfifo_wside #(.DEPTH(DEPTH)) wside_i (
        .clk(wclk), .rst_n(wrs[1]), .wen_n(wen_n), .rgray_s(rgray_s),
        .clr_tog_s(clr_tog_s), .waddr(waddr), .wr_en(wr_en), .wgray(wgray),
        .full_n(full_n), .set_tog(set_tog));

    dcfifo_rside #(.DEPTH(DEPTH), .DATA_W(DATA_W)) rside_i (
        .clk(rclk), .rst_n(rrs[1]), .ren_n(ren_n), .wgray_s(wgray_s),
        .set_tog_s(set_tog_s), .rd_data(mem[raddr]), .raddr(raddr),
        .rgray(rgray), .empty_n(empty_n), .clr_tog(clr_tog), .dout(q));

    dcfifo_sync #(.W(PW + 1)) w2r_i (.clk(rclk), .rst_n(rrs[1]),
        .d({set_tog, wgray}), .q({set_tog_s, wgray_s}));
    dcfifo_sync #(.W(PW + 1)) r2w_i (.clk(wclk), .rst_n(wrs[1]),
        .d({clr_tog, rgray}), .q({clr_tog_s, rgray_s}));

    // Storage array, written on the write clock only.
    always_ff @(posedge wclk) if (wr_en) mem[waddr] <= din;

    // Half-full is pending while the set and clear events disagree.
    assign half_n = (set_tog == clr_tog);
    assign q_en   = !oe_n;

    AST_HALF_HIGH_IN_RESET: assert property (@(posedge wclk)
        ($past(!wrs[1]) && !rrs[1]) |-> half_n); // R1
endmodule

// File: tb/dcfifo_hf_tb_top.sv
module dcfifo_hf_tb_top;
    localparam int D  = 16;
    localparam int DW = 16;

    logic clk = 1'b0, rst_n = 1'b0, wen_n = 1'b1, ren_n = 1'b1, oe_n = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] q;
    logic q_en, empty_n, full_n, half_n;
    int checks = 0, fails = 0;
    logic [DW-1:0] mq[$];
    logic [DW-1:0] last_q = '0;

    always #4 clk = ~clk;

    dcfifo_hf #(.DEPTH(D), .DATA_W(DW)) dut_i (
        .wclk(clk), .rclk(clk), .rst_n(rst_n), .wen_n(wen_n), .din(din),
        .ren_n(ren_n), .oe_n(oe_n), .q(q), .q_en(q_en), .empty_n(empty_n),
        .full_n(full_n), .half_n(half_n));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [DW-1:0] d);
        @(negedge clk); wen_n = 1'b0; din = d;
        @(negedge clk); wen_n = 1'b1;
    endtask

    task automatic rd();
        @(negedge clk); ren_n = 1'b0;
        @(negedge clk); ren_n = 1'b1;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state, enables ignored during reset
        wen_n = 1'b0; ren_n = 1'b0; din = 16'hDEAD;
        idle(6);
        chk("R1 full_n in reset", full_n, 1); chk("R1 empty_n in reset", empty_n, 0);
        chk("R1 half_n in reset", half_n, 1); chk("R1 q in reset", q, 0);
        wen_n = 1'b1; ren_n = 1'b1; rst_n = 1'b1;
        idle(6);
        chk("R1 empty_n after release", empty_n, 0); chk("R1 q after release", q, 0);
        chk("R1 full_n after release", full_n, 1); chk("R1 half_n after release", half_n, 1);

        // Sweep every fill level
        for (int n = 1; n <= D; n++) begin
            for (int k = 1; k <= n; k++) begin
                wr(16'h5A00 ^ {n[7:0], k[7:0]});
                chk("R8 half_n after write", half_n, (k > D/2) ? 0 : 1);
                chk("R3 full_n after write", full_n, (k == D) ? 0 : 1);
            end
            if (n == D) begin
                wr(16'hFFFF); // R3: dropped while full
                chk("R3 full_n holds", full_n, 0);
            end
            idle(5);
            chk("R7 empty_n risen", empty_n, 1);
            chk("R5 q not fall-through", q, last_q);
            for (int k = 1; k <= n; k++) begin
                rd();
                last_q = 16'h5A00 ^ {n[7:0], k[7:0]};
                chk("R2 R4 read data", q, last_q);
                chk("R9 half_n after read", half_n, (n - k > D/2) ? 0 : 1);
                chk("R6 empty_n after read", empty_n, (k == n) ? 0 : 1);
                if (n == D && k == 1) begin
                    idle(4);
                    chk("R7 full_n risen", full_n, 1);
                end
            end
            rd();
            chk("R6 q held on empty read", q, last_q);
            chk("R6 empty_n stays low", empty_n, 0);
            idle(4);
        end

        // R4: hold with ren_n high
        wr(16'h1234); idle(5);
        idle(3);
        chk("R4 q held idle", q, last_q);
        rd(); last_q = 16'h1234;
        chk("R4 q loaded", q, last_q);

        // R10: output enable
        @(negedge clk); oe_n = 1'b1; #1;
        chk("R10 q_en released", q_en, 0);
        @(negedge clk); oe_n = 1'b0; #1;
        chk("R10 q_en driven", q_en, 1); chk("R10 q value", q, last_q);

        // Simultaneous write and read each cycle
        for (int k = 0; k < 4; k++) begin wr(16'hA000 + 16'(k)); mq.push_back(16'hA000 + 16'(k)); end
        idle(5);
        for (int k = 0; k < 24; k++) begin
            logic e, f;
            @(negedge clk);
            e = empty_n; f = full_n;
            wen_n = 1'b0; ren_n = 1'b0; din = 16'hB000 + 16'(k);
            @(negedge clk);
            wen_n = 1'b1; ren_n = 1'b1;
            if (e) last_q = mq.pop_front();
            if (f) mq.push_back(16'hB000 + 16'(k));
            chk("R2 R4 streaming data", q, last_q);
        end
        idle(5);
        while (mq.size() > 0) begin rd(); last_q = mq.pop_front(); chk("R2 drain order", q, last_q); end
        chk("R6 drained empty", empty_n, 0);

        // R11: reset with data stored
        for (int k = 0; k < 5; k++) wr(16'hC000 + 16'(k));
        @(negedge clk); rst_n = 1'b0; wen_n = 1'b0; din = 16'hEEEE;
        idle(4);
        @(negedge clk); rst_n = 1'b1; wen_n = 1'b1;
        idle(6);
        chk("R11 empty after reset", empty_n, 0); chk("R11 q cleared", q, 0);
        chk("R11 half_n after reset", half_n, 1);
        wr(16'h7777); idle(5);
        rd();
        chk("R11 first word after reset", q, 16'h7777);
        chk("R11 empty after single", empty_n, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule